// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a logical address into a physical address by looking up one entry of a page table kept in main memory. A requester presents a logical address together with an access kind (read, write or execute). The block splits the address into a page number (upper bits) and a byte offset (lower bits), because the page size is a power of two. It compares the page number against the table length setting and, if the page is in range, fetches exactly one table entry through a simple memory read port. The entry address is the table base plus the page number times the entry size.

The fetched entry supplies the frame number together with a valid flag and read, write and execute permission flags. The block answers with either a physical address or a two-bit fault code. The physical address is the frame number followed by the unchanged offset. The data access that follows a successful translation is the requester's own second memory read and is not issued here.

Requests and responses use valid/ready handshakes. The block serves one translation at a time.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A successful translation returns fault 0 and a physical address made of the entry's frame field (entry bits [31:12] by default) followed by the 12 unchanged offset bits of the logical address.
- R3: For an in-range page number, exactly one entry read is issued, at address `ptbr + page*4`. The address is held stable while `mem_req_ready` is low.
- R4: If the page number (logical address bits [31:12]) is at or above `ptlr`, the response is fault 1 (length) with physical address 0, and no memory read is issued. The page `ptlr-1` is still translated.
- R5: An entry whose valid flag (bit 0) is 0 gives fault 2 (invalid), whatever its permission flags are.
- R6: A read (access code 0) needs the read flag (bit 1), and a write (access code 1) needs the write flag (bit 2). Without the needed flag, the response is fault 3 (protection).
- R7: An execute (access code 2) needs the execute flag (bit 3). On an execute-only page (execute flag set, read flag clear), a read gives fault 3.
- R8: Fault priority is length over invalid over protection.
- R9: A response stays asserted with stable address and fault until `rsp_ready` is high. `req_ready` is 0 from the accepted request until the response is taken.
- R10: Access code 3 is reserved and always gives fault 3 on a valid in-range entry.
- R11: Any faulting response carries physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | MEM_AW | Byte address of the page table start |
| ptlr | input | LEN_W | Number of entries in the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | LA_W | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MEM_AW | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | ENTRY_BYTES*8 | Entry word |

## Verification
Translations are tried on pages with different permission sets (read-write, read-only, execute-only, all flags) under each access kind. This separates a correct permission decode from one that swaps or ignores a flag. Invalid entries, one with permissions and one without, show that the valid flag wins over protection. Page numbers just below, at and far above the length, plus a zero length, expose off-by-one and compare-width errors, and the bench counts memory reads to confirm that none is issued on a length fault. A stalled memory port and a delayed response accept show that the read address and the response are held.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_LEN     = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_PROT    = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      ACC_RD   = 2'd0,
      ACC_WR   = 2'd1,
      ACC_EX   = 2'd2,
      ACC_RSVD = 2'd3
   } acc_e;

   localparam int FLAG_V = 0;
   localparam int FLAG_R = 1;
   localparam int FLAG_W = 2;
   localparam int FLAG_X = 3;
   localparam int FLAG_N = 4;

endpackage

// File: rtl/pt_split.sv
module pt_split #(
   parameter int LA_W        = 32,
   parameter int PAGE_BITS   = 12,
   parameter int LEN_W       = 20,
   parameter int MEM_AW      = 32,
   parameter int ENTRY_SHIFT = 2,
   localparam int VPN_W      = LA_W - PAGE_BITS
) (
   input  logic [LA_W-1:0]      laddr,
   input  logic [MEM_AW-1:0]    ptbr,
   input  logic [LEN_W-1:0]     ptlr,
   output logic [PAGE_BITS-1:0] offset,
   output logic                 in_range,
   output logic [MEM_AW-1:0]    ent_addr
);

   logic [VPN_W-1:0] vpn;

   assign vpn    = laddr[LA_W-1:PAGE_BITS];
   assign offset = laddr[PAGE_BITS-1:0];

   // Length compare: widen whichever side is narrower
   generate
      if (LEN_W > VPN_W) begin : g_wide_len
         assign in_range = LEN_W'(vpn) < ptlr;
      end else if (LEN_W < VPN_W) begin : g_wide_vpn
         assign in_range = vpn < VPN_W'(ptlr);
      end else begin : g_same
         assign in_range = vpn < ptlr;
      end
   endgenerate

   assign ent_addr = ptbr + (MEM_AW'(vpn) << ENTRY_SHIFT);

endmodule

// File: rtl/pt_check.sv
module pt_check #(
   parameter int ENTRY_W   = 32,
   parameter int FRAME_W   = 20,
   parameter int PAGE_BITS = 12,
   parameter int PA_W      = 32
) (
   input  logic [ENTRY_W-1:0]   entry,
   input  logic [1:0]           acc,
   input  logic [PAGE_BITS-1:0] offset,
   output logic [1:0]           fault,
   output logic [PA_W-1:0]      paddr
);
   import pt_xlate_pkg::*;

   logic [FRAME_W-1:0] frame;
   logic [FLAG_N-1:0]  flags;
   logic               allowed;

   assign frame = entry[ENTRY_W-1 -: FRAME_W];
   assign flags = entry[FLAG_N-1:0];

   always_comb begin
      unique case (acc)
         ACC_RD:  allowed = flags[FLAG_R];
         ACC_WR:  allowed = flags[FLAG_W];
         ACC_EX:  allowed = flags[FLAG_X];
         default: allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (!flags[FLAG_V]) begin
         fault = FLT_INVALID;
         paddr = '0;
      end else if (!allowed) begin
         fault = FLT_PROT;
         paddr = '0;
      end else begin
         fault = FLT_NONE;
         paddr = {frame, offset};
      end
   end

   always_comb begin
      if (!flags[FLAG_V]) a_r5_invalid_first : assert (fault == FLT_INVALID);
   end

endmodule

// File: rtl/pt_seq.sv
module pt_seq #(
   parameter int MEM_AW    = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_acc,
   input  logic                 req_in_range,
   input  logic [MEM_AW-1:0]    req_ent_addr,
   input  logic [PAGE_BITS-1:0] req_offset,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [MEM_AW-1:0]    mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [1:0]           chk_fault,
   input  logic [PA_W-1:0]      chk_paddr,
   output logic [1:0]           acc_q,
   output logic [PAGE_BITS-1:0] off_q,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic [1:0]           rsp_fault
);
   import pt_xlate_pkg::*;

   typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_RESP} st_e;

   st_e               state;
   logic [MEM_AW-1:0] addr_q;
   logic [PA_W-1:0]   pa_q;
   logic [1:0]        fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         addr_q  <= '0;
         pa_q    <= '0;
         fault_q <= FLT_NONE;
         acc_q   <= '0;
         off_q   <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (req_valid) begin
               acc_q <= req_acc;
               off_q <= req_offset;
               if (req_in_range) begin
                  addr_q <= req_ent_addr;
                  state  <= S_READ;
               end else begin
                  fault_q <= FLT_LEN;
                  pa_q    <= '0;
                  state   <= S_RESP;
               end
            end
            S_READ: if (mem_req_ready) state <= S_WAIT;
            S_WAIT: if (mem_rsp_valid) begin
               fault_q <= chk_fault;
               pa_q    <= chk_paddr;
               state   <= S_RESP;
            end
            S_RESP: if (rsp_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == S_IDLE);
   assign mem_req_valid = (state == S_READ);
   assign mem_req_addr  = addr_q;
   assign rsp_valid     = (state == S_RESP);
   assign rsp_paddr     = pa_q;
   assign rsp_fault     = fault_q;

   a_r9_rsp_hold : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

   a_r3_addr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   a_r3_single_read : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   a_r4_len_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_in_range |=> rsp_valid && rsp_fault == FLT_LEN && !mem_req_valid);

   a_r11_fault_zero_pa : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != FLT_NONE |-> rsp_paddr == '0);

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
   parameter int LA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BITS   = 12,
   parameter int MEM_AW      = 32,
   parameter int LEN_W       = 20,
   parameter int ENTRY_BYTES = 4,
   localparam int ENTRY_W     = ENTRY_BYTES * 8,
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES),
   localparam int VPN_W       = LA_W - PAGE_BITS,
   localparam int FRAME_W     = PA_W - PAGE_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MEM_AW-1:0]  ptbr,
   input  logic [LEN_W-1:0]   ptlr,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [LA_W-1:0]    req_laddr,
   input  logic [1:0]         req_acc,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [1:0]         rsp_fault,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [MEM_AW-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data
);

   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= LA_W || PAGE_BITS >= PA_W) begin : g_bad_page
         $error("pt_xlate: PAGE_BITS out of range");
      end
      if ((1 << ENTRY_SHIFT) != ENTRY_BYTES) begin : g_bad_entry
         $error("pt_xlate: ENTRY_BYTES must be a power of two");
      end
      if (FRAME_W > ENTRY_W - pt_xlate_pkg::FLAG_N) begin : g_bad_frame
         $error("pt_xlate: frame field overlaps flag bits");
      end
      if (MEM_AW < VPN_W + ENTRY_SHIFT) begin : g_bad_aw
         $error("pt_xlate: MEM_AW too narrow for table offset");
      end
   endgenerate

   logic [PAGE_BITS-1:0] req_off, off_q;
   logic                 in_range;
   logic [MEM_AW-1:0]    ent_addr;
   logic [1:0]           acc_q, chk_fault;
   logic [PA_W-1:0]      chk_paddr;

   pt_split #(
      .LA_W(LA_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W),
      .MEM_AW(MEM_AW), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_split (
      .laddr(req_laddr), .ptbr(ptbr), .ptlr(ptlr),
      .offset(req_off), .in_range(in_range), .ent_addr(ent_addr)
   );

   pt_check #(
      .ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
   ) u_check (
      .entry(mem_rsp_data), .acc(acc_q), .offset(off_q),
      .fault(chk_fault), .paddr(chk_paddr)
   );

   pt_seq #(
      .MEM_AW(MEM_AW), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_acc(req_acc),
      .req_in_range(in_range), .req_ent_addr(ent_addr), .req_offset(req_off),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .chk_fault(chk_fault), .chk_paddr(chk_paddr),
      .acc_q(acc_q), .off_q(off_q),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
   );

endmodule

// File: tb/tb_pt_xlate.sv
module tb_pt_xlate;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ptbr = BASE;
   logic [19:0] ptlr = 20'd8;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   int rd_cnt = 0;
   int cycles = 0;
   logic [31:0] last_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_xlate dut (
      .clk(clk), .rst_n(rst_n), .ptbr(ptbr), .ptlr(ptlr),
      .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr), .req_acc(req_acc),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   // Page table image: {frame[19:0], 8'h0, X W R V}
   function automatic logic [31:0] tbl(input logic [31:0] a);
      logic [31:0] i;
      i = (a - BASE) >> 2;
      case (i)
         0: return {20'h00ABC, 8'h0, 4'b0111};
         1: return {20'h12345, 8'h0, 4'b0011};
         2: return {20'h00777, 8'h0, 4'b1001};
         3: return {20'h55555, 8'h0, 4'b0110};
         4: return {20'h66666, 8'h0, 4'b0000};
         5: return {20'hFFFFF, 8'h0, 4'b1111};
         7: return {20'h00042, 8'h0, 4'b0011};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= tbl(mem_req_addr);
         rd_cnt        <= rd_cnt + 1;
         last_rd       <= mem_req_addr;
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
   end

   // One translation; rsp_ready raised after hold_cycles
   task automatic xlate(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] acc,
                        input logic [1:0] exp_f, input logic [31:0] exp_pa, input string tag,
                        input int hold_cycles = 0);
      int rd0;
      int w;
      logic [31:0] pa0;
      rd0 = rd_cnt;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_laddr = {vpn, off};
      req_acc   = acc;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      w = 0;
      while (!rsp_valid && w < 50) begin
         check(!req_ready, {tag, " busy"}, 32'(req_ready), 32'd0);
         @(negedge clk);
         w++;
      end
      check(rsp_valid, {tag, " rsp"}, 32'(rsp_valid), 32'd1);
      pa0 = rsp_paddr;
      for (int k = 0; k < hold_cycles; k++) begin
         @(negedge clk);
         check(rsp_valid && !req_ready && rsp_paddr == pa0, {tag, " R9 hold"}, rsp_paddr, pa0);
      end
      check(rsp_fault == exp_f, {tag, " fault"}, 32'(rsp_fault), 32'(exp_f));
      check(rsp_paddr == exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
      if (exp_f == 2'd1) begin
         check(rd_cnt == rd0, {tag, " R4 no read"}, 32'(rd_cnt - rd0), 32'd0);
      end else begin
         check(rd_cnt == rd0 + 1, {tag, " R3 one read"}, 32'(rd_cnt - rd0), 32'd1);
         check(last_rd == ptbr + {10'd0, vpn, 2'b00}, {tag, " R3 addr"}, last_rd,
               ptbr + {10'd0, vpn, 2'b00});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset",
            {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
   endtask

   task automatic t_permitted();
      xlate(20'h0, 12'h123, 2'd0, 2'd0, 32'h00ABC123, "R2 rd rw-page");
      xlate(20'h0, 12'hFFF, 2'd1, 2'd0, 32'h00ABCFFF, "R2 wr rw-page");
      xlate(20'h5, 12'h000, 2'd2, 2'd0, 32'hFFFFF000, "R2 ex all-page");
      xlate(20'h1, 12'hABC, 2'd0, 2'd0, 32'h12345ABC, "R6 rd ro-page");
   endtask

   task automatic t_protection();
      xlate(20'h1, 12'h001, 2'd1, 2'd3, 32'h0, "R6 wr ro-page");
      xlate(20'h2, 12'h010, 2'd2, 2'd0, 32'h00777010, "R7 ex xo-page");
      xlate(20'h2, 12'h010, 2'd0, 2'd3, 32'h0, "R7 rd xo-page");
      xlate(20'h0, 12'h004, 2'd2, 2'd3, 32'h0, "R7 ex rw-page");
      xlate(20'h5, 12'h004, 2'd3, 2'd3, 32'h0, "R10 reserved acc");
   endtask

   task automatic t_invalid();
      xlate(20'h3, 12'h000, 2'd0, 2'd2, 32'h0, "R5 invalid rd");
      xlate(20'h4, 12'h000, 2'd1, 2'd2, 32'h0, "R8 invalid no-perm");
   endtask

   task automatic t_length();
      xlate(20'h7, 12'h001, 2'd0, 2'd0, 32'h00042001, "R4 last page");
      xlate(20'h8, 12'h001, 2'd0, 2'd1, 32'h0, "R4 at length");
      xlate(20'hFFFFF, 12'h001, 2'd0, 2'd1, 32'h0, "R4 far above");
      ptlr = 20'd0;
      xlate(20'h0, 12'h001, 2'd0, 2'd1, 32'h0, "R8 zero length");
      ptlr = 20'd8;
   endtask

   task automatic t_stall();
      fork
         begin
            mem_req_ready = 1'b0;
            repeat (4) @(negedge clk);
            check(mem_req_valid && mem_req_addr == BASE + 32'h4, "R3 stalled addr",
                  mem_req_addr, BASE + 32'h4);
            mem_req_ready = 1'b1;
         end
         xlate(20'h1, 12'h055, 2'd0, 2'd0, 32'h12345055, "R9 stalled", 3);
      join
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_permitted();
      t_protection();
      t_invalid();
      t_length();
      t_stall();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule